// File: doc/BRIEF.md
# Byte-Bus Register Mapper with Indirect Word Port

This block sits on an 8-bit host bus and presents a 32-byte register file. Most bytes are plain storage that reads back whatever was written last. A few offsets are commands. They drive a reset line for a second processor, a sound-data strobe, and an interrupt level encoded in inverted form. A command byte also starts a single word transfer into the second processor's address space. The address for that transfer is assembled from three latched bytes. The upper sixteen bytes hold mapping configuration for an external decoder, and a one-cycle pulse tells that decoder when any of these bytes has actually changed.

The host writes one byte per cycle with `host_we`. The read data is combinational from the offset on `host_addr`. Only the low five address bits select a register, so the space repeats every 32 bytes. An indirect transfer is a plain request/ready handshake toward the target memory. While it is outstanding, `busy` is high and further command writes are refused.

Top module: `regmap_bridge`

## Requirements
- R1: Only `host_addr[4:0]` selects a register, so addresses 32 apart alias. Every register reads back on `host_rdata` the last byte stored in it. Reset clears all 32 registers and every output to zero.
- R2: A write to offset 2 changes `tgt_reset` only when bits [1:0] of the new byte differ from the stored ones. When it does, `tgt_reset` becomes 1 if both bits are 1 and 0 otherwise. The new value shows in the cycle after the write.
- R3: A write to offset 3 raises `snd_strobe` for exactly the following cycle. `snd_data` then shows the written byte. No other offset raises the strobe.
- R4: A write to offset 4 whose bits [2:0] are not 3'b111 sets `irq_level` to the bitwise inverse of those bits from the next cycle on. Writing 0x0B therefore gives level 4. A write with bits [2:0] equal to 3'b111 leaves `irq_level` unchanged.
- R5: Writing 0x01 to offset 5 starts a word write. The word is {reg 0x00, reg 0x01}. The address is (reg0x0A<<17 | reg0x0B<<9 | reg0x0C<<1), truncated to 24 bits. `tgt_req` and `tgt_we` are high from the next cycle until a cycle with `tgt_ready` high.
- R6: Writing 0x02 to offset 5 starts a word read with `tgt_we` low. The address is (reg0x07<<17 | reg0x08<<9 | reg0x09<<1), truncated to 24 bits. In the cycle with `tgt_ready` high, the high byte of `tgt_rdata` is stored into reg 0x00 and the low byte into reg 0x01.
- R7: `busy` is high while a transfer is outstanding. A write to offset 5 during that time is dropped entirely: the register keeps its value and no further transfer starts. While `tgt_ready` is low, `tgt_req`, `tgt_we` and `tgt_addr` stay stable.
- R8: A write to an offset in 0x10 to 0x1F raises `remap_pulse` for one cycle only if the new byte differs from the stored one. Writes to other offsets never raise it.
- R9: Writes to offsets 0x07 to 0x0C only store the byte. So does a write to offset 5 of any value other than 0x01 or 0x02. None of these starts a transfer or raises a pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | 8 | Host byte address; low 5 bits select the register |
| host_we | input | 1 | Host write enable, one byte per cycle |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Register contents at the current offset |
| tgt_req | output | 1 | Indirect transfer request |
| tgt_we | output | 1 | 1 for a word write, 0 for a word read |
| tgt_addr | output | 24 | Target byte address of the word |
| tgt_wdata | output | 16 | Word to write |
| tgt_rdata | input | 16 | Word returned by a read |
| tgt_ready | input | 1 | Target completes the transfer in this cycle |
| tgt_reset | output | 1 | Reset request toward the target processor |
| irq_level | output | 3 | Interrupt level toward the target processor |
| snd_strobe | output | 1 | One-cycle strobe after a sound-byte write |
| snd_data | output | 8 | Last sound byte written |
| remap_pulse | output | 1 | One-cycle pulse after a changed mapping byte |
| busy | output | 1 | Indirect transfer outstanding |

## Verification
The bench builds the block with its default parameters: a 5-bit register offset, an 8-bit host address and a 24-bit target address. With these values every offset can be reached through all eight aliases. All 256 byte values fit in a full sweep of the reset-control and interrupt offsets. The sixteen mapping bytes can each be tried with a repeated and a changed value. The target model answers after a configurable number of wait cycles. This lets the refused command write and the held request be observed during a long transfer, and the expected address and read-back bytes are computed from the latched address bytes.

// File: rtl/regmap_pkg.sv
package regmap_pkg;

    localparam int unsigned BYTE_W = 8;
    localparam int unsigned WORD_W = 16;

    // register offsets whose position is decoded by side-effect logic
    localparam int unsigned OFF_WORD_HI = 0;
    localparam int unsigned OFF_WORD_LO = 1;
    localparam int unsigned OFF_CTRL    = 2;
    localparam int unsigned OFF_SOUND   = 3;
    localparam int unsigned OFF_IRQ     = 4;
    localparam int unsigned OFF_CMD     = 5;
    localparam int unsigned OFF_RA_HI   = 7;
    localparam int unsigned OFF_RA_MID  = 8;
    localparam int unsigned OFF_RA_LO   = 9;
    localparam int unsigned OFF_WA_HI   = 10;
    localparam int unsigned OFF_WA_MID  = 11;
    localparam int unsigned OFF_WA_LO   = 12;

    localparam logic [BYTE_W-1:0] CMD_PUT_WORD = 8'h01;
    localparam logic [BYTE_W-1:0] CMD_GET_WORD = 8'h02;

    typedef enum logic [1:0] {
        XF_IDLE  = 2'd0,
        XF_WRITE = 2'd1,
        XF_READ  = 2'd2
    } xfer_state_e;

    // word address built from three latched bytes: hi<<17 | mid<<9 | lo<<1
    function automatic logic [31:0] build_addr(input logic [BYTE_W-1:0] hi,
                                               input logic [BYTE_W-1:0] mid,
                                               input logic [BYTE_W-1:0] lo);
        logic [31:0] a;
        a = ({24'd0, hi} << 17) | ({24'd0, mid} << 9) | ({24'd0, lo} << 1);
        return a;
    endfunction

endpackage

// File: rtl/regmap_irq_enc.sv
module regmap_irq_enc #(
    parameter int unsigned LVL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [LVL_W-1:0] wbits,
    output logic [LVL_W-1:0] level
);

    typedef struct packed {
        logic [LVL_W-1:0] level;
    } irq_state_t;

    irq_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // all-ones means "no request" in inverted encoding: keep level
        if (wr && (wbits != {LVL_W{1'b1}})) begin
            st_d.level = ~wbits;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign level = st_q.level;

endmodule

// File: rtl/regmap_remap_watch.sv
module regmap_remap_watch #(
    parameter int unsigned BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              is_map,
    input  logic [BYTE_W-1:0] old_val,
    input  logic [BYTE_W-1:0] new_val,
    output logic              pulse
);

    typedef struct packed {
        logic pulse;
    } watch_state_t;

    watch_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.pulse = wr_en && is_map && (old_val != new_val);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pulse = st_q.pulse;

endmodule

// File: rtl/regmap_xfer.sv
module regmap_xfer
    import regmap_pkg::*;
#(
    parameter int unsigned TGT_AW = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_wr,
    input  logic              start_rd,
    input  logic [TGT_AW-1:0] addr_wr,
    input  logic [TGT_AW-1:0] addr_rd,
    input  logic [WORD_W-1:0] word_wr,
    input  logic              tgt_ready,
    input  logic [WORD_W-1:0] tgt_rdata,
    output logic              tgt_req,
    output logic              tgt_we,
    output logic [TGT_AW-1:0] tgt_addr,
    output logic [WORD_W-1:0] tgt_wdata,
    output logic              busy,
    output logic              rd_done,
    output logic [WORD_W-1:0] rd_word
);

    typedef struct packed {
        xfer_state_e       state;
        logic [TGT_AW-1:0] addr;
        logic [WORD_W-1:0] wdata;
    } xfer_t;

    xfer_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q.state)
            XF_IDLE: begin
                if (start_wr) begin
                    st_d.state = XF_WRITE;
                    st_d.addr  = addr_wr;
                    st_d.wdata = word_wr;
                end else if (start_rd) begin
                    st_d.state = XF_READ;
                    st_d.addr  = addr_rd;
                end
            end
            XF_WRITE, XF_READ: begin
                if (tgt_ready) begin
                    st_d.state = XF_IDLE;
                end
            end
            default: st_d.state = XF_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{state: XF_IDLE, addr: '0, wdata: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign tgt_req   = (st_q.state != XF_IDLE);
    assign tgt_we    = (st_q.state == XF_WRITE);
    assign tgt_addr  = st_q.addr;
    assign tgt_wdata = st_q.wdata;
    assign busy      = tgt_req;
    assign rd_done   = (st_q.state == XF_READ) && tgt_ready;
    assign rd_word   = tgt_rdata;

endmodule

// File: rtl/regmap_bridge.sv
module regmap_bridge
    import regmap_pkg::*;
#(
    parameter int unsigned HOST_AW = 8,
    parameter int unsigned REG_AW  = 5,
    parameter int unsigned TGT_AW  = 24,
    parameter int unsigned LVL_W   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic               host_we,
    input  logic [7:0]         host_wdata,
    output logic [7:0]         host_rdata,
    output logic               tgt_req,
    output logic               tgt_we,
    output logic [TGT_AW-1:0]  tgt_addr,
    output logic [15:0]        tgt_wdata,
    input  logic [15:0]        tgt_rdata,
    input  logic               tgt_ready,
    output logic               tgt_reset,
    output logic [LVL_W-1:0]   irq_level,
    output logic               snd_strobe,
    output logic [7:0]         snd_data,
    output logic               remap_pulse,
    output logic               busy
);

    localparam int unsigned NREG    = 1 << REG_AW;
    localparam int unsigned MAP_BIT = REG_AW - 1;

    typedef struct packed {
        logic [NREG-1:0][BYTE_W-1:0] regs;
        logic                        rst_out;
        logic                        snd_stb;
    } bridge_t;

    bridge_t st_d, st_q;

    logic [REG_AW-1:0] off;
    logic              wr_ok;
    logic              start_wr;
    logic              start_rd;
    logic [31:0]       addr_wr_full;
    logic [31:0]       addr_rd_full;
    logic              rd_done;
    logic [WORD_W-1:0] rd_word;
    logic              xf_busy;

    assign off   = host_addr[REG_AW-1:0];
    // a command write while a transfer is outstanding is dropped
    assign wr_ok = host_we && !(xf_busy && (off == REG_AW'(OFF_CMD)));

    assign start_wr = wr_ok && (off == REG_AW'(OFF_CMD)) && (host_wdata == CMD_PUT_WORD);
    assign start_rd = wr_ok && (off == REG_AW'(OFF_CMD)) && (host_wdata == CMD_GET_WORD);

    assign addr_wr_full = build_addr(st_q.regs[OFF_WA_HI], st_q.regs[OFF_WA_MID],
                                     st_q.regs[OFF_WA_LO]);
    assign addr_rd_full = build_addr(st_q.regs[OFF_RA_HI], st_q.regs[OFF_RA_MID],
                                     st_q.regs[OFF_RA_LO]);

    always_comb begin
        st_d         = st_q;
        st_d.snd_stb = 1'b0;
        if (wr_ok) begin
            st_d.regs[off] = host_wdata;
            if (off == REG_AW'(OFF_CTRL)) begin
                if ((st_q.regs[OFF_CTRL][1:0] ^ host_wdata[1:0]) != 2'b00) begin
                    st_d.rst_out = (host_wdata[1:0] == 2'b11);
                end
            end
            if (off == REG_AW'(OFF_SOUND)) begin
                st_d.snd_stb = 1'b1;
            end
        end
        // completed read lands in the data word bytes
        if (rd_done) begin
            st_d.regs[OFF_WORD_HI] = rd_word[WORD_W-1:BYTE_W];
            st_d.regs[OFF_WORD_LO] = rd_word[BYTE_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    regmap_xfer #(
        .TGT_AW (TGT_AW)
    ) u_xfer (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_wr  (start_wr),
        .start_rd  (start_rd),
        .addr_wr   (addr_wr_full[TGT_AW-1:0]),
        .addr_rd   (addr_rd_full[TGT_AW-1:0]),
        .word_wr   ({st_q.regs[OFF_WORD_HI], st_q.regs[OFF_WORD_LO]}),
        .tgt_ready (tgt_ready),
        .tgt_rdata (tgt_rdata),
        .tgt_req   (tgt_req),
        .tgt_we    (tgt_we),
        .tgt_addr  (tgt_addr),
        .tgt_wdata (tgt_wdata),
        .busy      (xf_busy),
        .rd_done   (rd_done),
        .rd_word   (rd_word)
    );

    regmap_irq_enc #(
        .LVL_W (LVL_W)
    ) u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (wr_ok && (off == REG_AW'(OFF_IRQ))),
        .wbits (host_wdata[LVL_W-1:0]),
        .level (irq_level)
    );

    regmap_remap_watch #(
        .BYTE_W (BYTE_W)
    ) u_remap (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_ok),
        .is_map  (off[MAP_BIT]),
        .old_val (st_q.regs[off]),
        .new_val (host_wdata),
        .pulse   (remap_pulse)
    );

    assign host_rdata = st_q.regs[off];
    assign tgt_reset  = st_q.rst_out;
    assign snd_strobe = st_q.snd_stb;
    assign snd_data   = st_q.regs[OFF_SOUND];
    assign busy       = xf_busy;

endmodule

// File: rtl/regmap_bridge_chk.sv
module regmap_bridge_chk #(
    parameter int unsigned HOST_AW = 8,
    parameter int unsigned REG_AW  = 5,
    parameter int unsigned TGT_AW  = 24,
    parameter int unsigned LVL_W   = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic [HOST_AW-1:0] host_addr,
    input logic               host_we,
    input logic [7:0]         host_wdata,
    input logic [7:0]         host_rdata,
    input logic               tgt_req,
    input logic               tgt_we,
    input logic [TGT_AW-1:0]  tgt_addr,
    input logic [15:0]        tgt_wdata,
    input logic [15:0]        tgt_rdata,
    input logic               tgt_ready,
    input logic               tgt_reset,
    input logic [LVL_W-1:0]   irq_level,
    input logic               snd_strobe,
    input logic [7:0]         snd_data,
    input logic               remap_pulse,
    input logic               busy
);

    logic [REG_AW-1:0] off;
    assign off = host_addr[REG_AW-1:0];

    // R2: reset line moves only after a write to the control offset
    a_r2_reset_source: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(tgt_reset) |-> $past(host_we && (off == REG_AW'(2))));

    // R3: strobe follows a write to the sound offset
    a_r3_strobe_source: assert property (@(posedge clk) disable iff (!rst_n)
        snd_strobe |-> $past(host_we && (off == REG_AW'(3))));

    // R4: interrupt level moves only after a write to its offset
    a_r4_level_source: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(irq_level) |-> $past(host_we && (off == REG_AW'(4))));

    // R7: pending request holds its address and direction
    a_r7_request_held: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_req && !tgt_ready) |=> (tgt_req && $stable(tgt_addr) && $stable(tgt_we)));

    // R7: busy mirrors an outstanding request at the port
    a_r7_busy_matches: assert property (@(posedge clk) disable iff (!rst_n)
        busy == tgt_req);

    // R8: remap pulse follows a write in the mapping half
    a_r8_remap_source: assert property (@(posedge clk) disable iff (!rst_n)
        remap_pulse |-> $past(host_we && off[REG_AW-1]));

endmodule

bind regmap_bridge regmap_bridge_chk #(
    .HOST_AW (HOST_AW),
    .REG_AW  (REG_AW),
    .TGT_AW  (TGT_AW),
    .LVL_W   (LVL_W)
) i_chk (.*);

// File: tb/test_regmap_bridge.sv
`timescale 1ns/1ps
module test_regmap_bridge;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  host_addr = '0;
    logic        host_we = 1'b0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;
    logic        tgt_req;
    logic        tgt_we;
    logic [23:0] tgt_addr;
    logic [15:0] tgt_wdata;
    logic [15:0] tgt_rdata;
    logic        tgt_ready = 1'b0;
    logic        tgt_reset;
    logic [2:0]  irq_level;
    logic        snd_strobe;
    logic [7:0]  snd_data;
    logic        remap_pulse;
    logic        busy;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    int lat = 0;
    int wcnt = 0;
    int hs_cnt = 0;
    logic [23:0] hs_addr;
    logic        hs_we;
    logic [15:0] hs_wdata;

    always #5 clk = ~clk;

    regmap_bridge i_regmap_bridge (.*);

    function automatic logic [15:0] tgt_word(input logic [23:0] a);
        return a[15:0] ^ {a[23:16], a[23:16]} ^ 16'h3C5A;
    endfunction

    assign tgt_rdata = tgt_word(tgt_addr);

    // target model: ready after lat wait cycles
    always @(negedge clk) begin
        tgt_ready = 1'b0;
        if (tgt_req) begin
            if (wcnt >= lat) begin
                tgt_ready = 1'b1;
                hs_addr   = tgt_addr;
                hs_we     = tgt_we;
                hs_wdata  = tgt_wdata;
                hs_cnt++;
                wcnt = 0;
            end else begin
                wcnt++;
            end
        end else begin
            wcnt = 0;
        end
    end

    task automatic report();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected<150000 cycles", cycles);
            report();
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // drive a write, return 2ns after the capturing edge
    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        host_addr  = a;
        host_wdata = d;
        host_we    = 1'b1;
        @(posedge clk);
        #2;
        host_we = 1'b0;
    endtask

    task automatic idle();
        @(posedge clk);
        #2;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        host_addr = a;
        #1;
        d = host_rdata;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #2;
        rst_n = 1'b1;
        idle();
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 200 && busy; i++) idle();
    endtask

    logic [7:0] v;
    logic [7:0] prev;
    int         exp_lvl;
    int         exp_rst;
    int         hs0;
    logic [23:0] ea;

    initial begin
        do_reset();

        // R1: reset state
        for (int o = 0; o < 32; o++) begin
            rd(8'(o), v);
            chk(v == 8'h00, "R1 reset register", v, 0);
        end
        chk({tgt_req, tgt_reset, irq_level, snd_strobe, remap_pulse, busy} == '0,
            "R1 reset outputs", {tgt_req, tgt_reset, irq_level, snd_strobe, remap_pulse, busy}, 0);

        // R1: store through one alias, read through every alias
        for (int o = 0; o < 32; o++) begin
            wr(8'(o + 32 * (o % 8)), 8'((o * 29) ^ 8'hC6));
            wait_idle();
        end
        for (int o = 0; o < 32; o++) begin
            for (int k = 0; k < 8; k++) begin
                rd(8'(o + 32 * k), v);
                if (o > 1) chk(v == 8'((o * 29) ^ 8'hC6), "R1 alias readback", v, (o * 29) ^ 8'hC6);
            end
        end

        do_reset();

        // R2: full sweep of control byte
        exp_rst = 0;
        for (int i = 0; i < 256; i++) begin
            v = 8'((i * 37 + 11) & 255);
            wr(8'h02, v);
            exp_rst = (v[1:0] == 2'b11) ? 1 : 0;
            chk(tgt_reset == exp_rst[0], "R2 reset control", tgt_reset, exp_rst);
        end
        wr(8'h42, 8'h03);
        wr(8'h22, 8'hF7);
        chk(tgt_reset == 1'b1, "R2 unchanged low bits keep reset", tgt_reset, 1);

        // R4: full sweep of interrupt byte
        wr(8'h04, 8'h0B);
        chk(irq_level == 3'd4, "R4 0x0B gives level 4", irq_level, 4);
        exp_lvl = 4;
        for (int i = 0; i < 256; i++) begin
            v = 8'(i);
            wr(8'h84, v);
            if (v[2:0] != 3'b111) exp_lvl = int'(~v[2:0]);
            chk(irq_level == exp_lvl[2:0], "R4 inverted level", irq_level, exp_lvl);
        end

        // R3: strobe and sound byte
        for (int i = 0; i < 6; i++) begin
            v = 8'(i * 53 + 7);
            wr(8'h03 + 8'(32 * i), v);
            chk(snd_strobe == 1'b1, "R3 strobe after write", snd_strobe, 1);
            chk(snd_data == v, "R3 sound byte", snd_data, v);
            idle();
            chk(snd_strobe == 1'b0, "R3 strobe one cycle", snd_strobe, 0);
        end
        wr(8'h06, 8'h55);
        chk(snd_strobe == 1'b0, "R3 no strobe other offset", snd_strobe, 0);

        // R8: mapping bytes pulse only on change
        for (int o = 16; o < 32; o++) begin
            rd(8'(o), prev);
            wr(8'(o), prev);
            chk(remap_pulse == 1'b0, "R8 same value no pulse", remap_pulse, 0);
            wr(8'(o + 64), prev ^ 8'(o));
            chk(remap_pulse == 1'b1, "R8 changed value pulse", remap_pulse, 1);
            idle();
            chk(remap_pulse == 1'b0, "R8 pulse one cycle", remap_pulse, 0);
        end
        wr(8'h0F, 8'hAA);
        chk(remap_pulse == 1'b0, "R8 low half no pulse", remap_pulse, 0);

        // R9: address latches and other command values
        hs0 = hs_cnt;
        for (int o = 7; o <= 12; o++) begin
            wr(8'(o), 8'(o * 17 + 3));
            chk(!tgt_req && !remap_pulse && !snd_strobe, "R9 latch no side effect",
                {tgt_req, remap_pulse, snd_strobe}, 0);
        end
        wr(8'h05, 8'h03);
        chk(!tgt_req && !busy, "R9 other command value no transfer", tgt_req, 0);
        rd(8'h05, v);
        chk(v == 8'h03, "R9 command byte stored", v, 3);
        idle();
        chk(hs_cnt == hs0, "R9 no handshake", hs_cnt, hs0);

        // R5: indirect writes at several addresses and latencies
        for (int t = 0; t < 4; t++) begin
            lat = t * 2;
            wr(8'h00, 8'(t * 41 + 5));
            wr(8'h01, 8'(t * 73 + 9));
            wr(8'h0A, 8'(8'hF0 + t));
            wr(8'h0B, 8'(t * 31 + 1));
            wr(8'h0C, 8'(8'hFF - t));
            ea = 24'(({24'd0, 8'(8'hF0 + t)} << 17) | ({24'd0, 8'(t * 31 + 1)} << 9)
                     | ({24'd0, 8'(8'hFF - t)} << 1));
            hs0 = hs_cnt;
            wr(8'h05, 8'h01);
            chk(tgt_req && tgt_we && busy, "R5 write request raised", {tgt_req, tgt_we, busy}, 7);
            wait_idle();
            chk(hs_cnt == hs0 + 1, "R5 one handshake", hs_cnt, hs0 + 1);
            chk(hs_addr == ea, "R5 write address", hs_addr, ea);
            chk(hs_we == 1'b1, "R5 write direction", hs_we, 1);
            chk(hs_wdata == {8'(t * 41 + 5), 8'(t * 73 + 9)}, "R5 write word", hs_wdata,
                {8'(t * 41 + 5), 8'(t * 73 + 9)});
        end

        // R6: indirect reads
        for (int t = 0; t < 4; t++) begin
            lat = 3 - t;
            wr(8'h07, 8'(t * 97 + 128));
            wr(8'h08, 8'(t * 13 + 200));
            wr(8'h09, 8'(t * 59 + 4));
            ea = 24'(({24'd0, 8'(t * 97 + 128)} << 17) | ({24'd0, 8'(t * 13 + 200)} << 9)
                     | ({24'd0, 8'(t * 59 + 4)} << 1));
            wr(8'h25, 8'h02);
            chk(tgt_req && !tgt_we, "R6 read request raised", {tgt_req, tgt_we}, 2);
            wait_idle();
            chk(hs_addr == ea && hs_we == 1'b0, "R6 read address", hs_addr, ea);
            rd(8'h00, v);
            chk(v == tgt_word(ea)[15:8], "R6 high byte", v, tgt_word(ea)[15:8]);
            rd(8'h01, v);
            chk(v == tgt_word(ea)[7:0], "R6 low byte", v, tgt_word(ea)[7:0]);
        end

        // R7: command refused while busy
        lat = 6;
        hs0 = hs_cnt;
        wr(8'h05, 8'h01);
        chk(busy == 1'b1, "R7 busy during transfer", busy, 1);
        wr(8'h05, 8'h02);
        rd(8'h05, v);
        chk(v == 8'h01, "R7 command write dropped", v, 1);
        wr(8'hA5, 8'h7E);
        rd(8'h05, v);
        chk(v == 8'h01, "R7 aliased command dropped", v, 1);
        wait_idle();
        chk(busy == 1'b0, "R7 busy clears", busy, 0);
        repeat (10) idle();
        chk(hs_cnt == hs0 + 1, "R7 no extra transfer", hs_cnt, hs0 + 1);
        chk(hs_we == 1'b1, "R7 first command kept", hs_we, 1);

        report();
    end

endmodule